// File: doc/BRIEF.md
# Program Counter and Return-Stack Sequencer

This block holds the program counter for a 16-bit word-addressed instruction memory. It also manages a byte-addressed return stack in data memory. Each clock cycle it applies one control code to its registered program counter:

- step to the next instruction,
- jump to an absolute or relative target,
- call through an absolute or relative target,
- return from a call,
- skip over the following instruction.

Instruction fetch and condition evaluation are outside the block. A decoder upstream supplies the code, a signed 12-bit relative offset, a 16-bit absolute target and a flag that tells whether the instruction of interest occupies two words.

On a call, the block writes the 16-bit return address into stack memory through a byte-pair write port and moves the stack pointer down by two. On a return, it takes the return address from a byte-pair read port addressed just above the stack pointer and moves the pointer back up by two. The read port is combinational: data must be valid in the same cycle as the address, which is derived from the registered stack pointer. Relative targets are computed as PC + k + 1, and all program-counter arithmetic wraps modulo 2^16.

Top module: `prog_seq`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0 and the stack pointer to the parameter SP_TOP. Both values are visible at the first clock edge at which reset is sampled high.
- R2: Control code 0 (step) and control code 7 (reserved) advance the program counter. The step is 1 when the two-word input is low and 2 when it is high.
- R3: Control code 1 (absolute jump) loads the program counter with the absolute target input.
- R4: Control code 2 (relative jump) loads PC + k + 1. The offset k is a 12-bit two's-complement value covering -2048 to 2047, and the sum wraps modulo 2^16.
- R5: Control code 3 (absolute call) loads the absolute target and pushes PC + 2 as the return address. The stack pointer decreases by 2.
- R6: Control code 4 (relative call) loads PC + k + 1 and pushes PC + 1 as the return address. The stack pointer decreases by 2.
- R7: The stack write enable is high only in cycles that carry a call code. The write address is SP - 1. Write data bits [7:0] hold the return address high byte, which goes to the write address. Bits [15:8] hold the low byte, which goes to write address + 1, that is, to SP.
- R8: The stack read address is always SP + 1. Read data bits [7:0] come from that address and bits [15:8] from the next one. Control code 5 (return) loads the program counter with {read[7:0], read[15:8]} and increases the stack pointer by 2.
- R9: Control code 6 (skip) advances the program counter by 2 when the two-word input is low and by 3 when it is high.
- R10: All codes other than 3, 4 and 5 leave the stack pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_i | input | 3 | Control code for this cycle |
| two_word_i | input | 1 | Instruction-length flag: high means two words |
| rel_off_i | input | 12 | Signed relative offset k |
| abs_tgt_i | input | 16 | Absolute jump or call target |
| st_rd_data_i | input | 16 | Stack read data (byte at read address in [7:0]) |
| pc_o | output | 16 | Registered program counter |
| sp_o | output | 16 | Registered stack pointer |
| st_we_o | output | 1 | Stack write enable |
| st_wr_addr_o | output | 16 | Stack write byte address (SP - 1) |
| st_wr_data_o | output | 16 | Return address bytes, high byte in [7:0] |
| st_rd_addr_o | output | 16 | Stack read byte address (SP + 1) |

## Verification
The assertions assume the following about the inputs:
- the control code and the length flag are stable across each sampling edge;
- the stack read data reflects the bytes written by earlier calls in LIFO order.

Relative-jump and return checks therefore depend only on values the checker can see in the previous cycle. The stimulus meets these assumptions as follows:
- inputs change only on the falling edge;
- the bench models the stack as a byte array written on the rising edge and read combinationally;
- returns never outnumber the calls that preceded them.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;
  typedef enum logic [2:0] {
    CTL_NEXT = 3'd0,
    CTL_JABS = 3'd1,
    CTL_JREL = 3'd2,
    CTL_CABS = 3'd3,
    CTL_CREL = 3'd4,
    CTL_RET  = 3'd5,
    CTL_SKIP = 3'd6,
    CTL_RSVD = 3'd7
  } ctl_e;

  function automatic logic ctl_is_call(ctl_e c);
    return (c == CTL_CABS) || (c == CTL_CREL);
  endfunction

  function automatic logic ctl_is_ret(ctl_e c);
    return c == CTL_RET;
  endfunction
endpackage

// File: rtl/prog_seq_target.sv
module prog_seq_target
  import prog_seq_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 12
) (
  input  ctl_e              ctl,
  input  logic              two_word,
  input  logic [PC_W-1:0]   pc,
  input  logic [OFF_W-1:0]  rel_off,
  input  logic [PC_W-1:0]   abs_tgt,
  input  logic [PC_W-1:0]   popped,
  output logic [PC_W-1:0]   pc_nxt,
  output logic [PC_W-1:0]   ret_addr
);
  localparam int EXT_W = PC_W - OFF_W;

  logic [PC_W-1:0] off_ext;
  logic [PC_W-1:0] rel_tgt;
  logic [PC_W-1:0] seq_step;
  logic [PC_W-1:0] skip_step;

  generate
    if (EXT_W > 0) begin : g_sext
      assign off_ext = {{EXT_W{rel_off[OFF_W-1]}}, rel_off};
    end else begin : g_trunc
      assign off_ext = rel_off[PC_W-1:0];
    end
  endgenerate

  assign rel_tgt   = pc + off_ext + PC_W'(1);
  assign seq_step  = two_word ? PC_W'(2) : PC_W'(1);
  assign skip_step = two_word ? PC_W'(3) : PC_W'(2);

  always_comb begin
    ret_addr = pc + PC_W'(1);
    pc_nxt   = pc + seq_step;
    unique case (ctl)
      CTL_JABS: pc_nxt = abs_tgt;
      CTL_JREL: pc_nxt = rel_tgt;
      CTL_CABS: begin
        pc_nxt   = abs_tgt;
        ret_addr = pc + PC_W'(2);
      end
      CTL_CREL: pc_nxt = rel_tgt;
      CTL_RET:  pc_nxt = popped;
      CTL_SKIP: pc_nxt = pc + skip_step;
      default:  pc_nxt = pc + seq_step;
    endcase
  end
endmodule

// File: rtl/prog_seq_sptr.sv
module prog_seq_sptr #(
  parameter int              SP_W   = 16,
  parameter logic [SP_W-1:0] SP_TOP = 16'h3FFF
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic            pop,
  output logic [SP_W-1:0] sp_q,
  output logic [SP_W-1:0] wr_addr,
  output logic [SP_W-1:0] rd_addr
);
  localparam logic [SP_W-1:0] FRAME = SP_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q <= SP_TOP;
    end else if (push) begin
      sp_q <= sp_q - FRAME;
    end else if (pop) begin
      sp_q <= sp_q + FRAME;
    end
  end

  assign wr_addr = sp_q - SP_W'(1);
  assign rd_addr = sp_q + SP_W'(1);
endmodule

// File: rtl/prog_seq.sv
module prog_seq
  import prog_seq_pkg::*;
#(
  parameter int              PC_W   = 16,
  parameter int              SP_W   = 16,
  parameter int              OFF_W  = 12,
  parameter logic [SP_W-1:0] SP_TOP = 16'h3FFF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       ctl_i,
  input  logic             two_word_i,
  input  logic [OFF_W-1:0] rel_off_i,
  input  logic [PC_W-1:0]  abs_tgt_i,
  input  logic [PC_W-1:0]  st_rd_data_i,
  output logic [PC_W-1:0]  pc_o,
  output logic [SP_W-1:0]  sp_o,
  output logic             st_we_o,
  output logic [SP_W-1:0]  st_wr_addr_o,
  output logic [PC_W-1:0]  st_wr_data_o,
  output logic [SP_W-1:0]  st_rd_addr_o
);
  localparam int BYTE_W = PC_W / 2;

  ctl_e            ctl;
  logic            push;
  logic            pop;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_nxt;
  logic [PC_W-1:0] ret_addr;
  logic [PC_W-1:0] popped;

  assign ctl  = ctl_e'(ctl_i);
  assign push = ctl_is_call(ctl);
  assign pop  = ctl_is_ret(ctl);

  // lower byte lane carries the byte stored at the lower address (high half)
  assign popped = {st_rd_data_i[BYTE_W-1:0], st_rd_data_i[PC_W-1:BYTE_W]};

  prog_seq_target #(
    .PC_W (PC_W),
    .OFF_W(OFF_W)
  ) u_tgt (
    .ctl     (ctl),
    .two_word(two_word_i),
    .pc      (pc_q),
    .rel_off (rel_off_i),
    .abs_tgt (abs_tgt_i),
    .popped  (popped),
    .pc_nxt  (pc_nxt),
    .ret_addr(ret_addr)
  );

  prog_seq_sptr #(
    .SP_W  (SP_W),
    .SP_TOP(SP_TOP)
  ) u_sp (
    .clk    (clk),
    .rst    (rst),
    .push   (push),
    .pop    (pop),
    .sp_q   (sp_o),
    .wr_addr(st_wr_addr_o),
    .rd_addr(st_rd_addr_o)
  );

  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_nxt;
  end

  assign pc_o         = pc_q;
  assign st_we_o      = push;
  assign st_wr_data_o = {ret_addr[BYTE_W-1:0], ret_addr[PC_W-1:BYTE_W]};
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
  parameter int              PC_W   = 16,
  parameter int              SP_W   = 16,
  parameter logic [SP_W-1:0] SP_TOP = 16'h3FFF
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      ctl_i,
  input logic            two_word_i,
  input logic [PC_W-1:0] abs_tgt_i,
  input logic [PC_W-1:0] pc_o,
  input logic [SP_W-1:0] sp_o,
  input logic            st_we_o,
  input logic [SP_W-1:0] st_wr_addr_o,
  input logic [SP_W-1:0] st_rd_addr_o
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (pc_o == '0 && sp_o == SP_TOP)); // R1
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == 3'd0 && !two_word_i) |=> pc_o == $past(pc_o) + PC_W'(1)); // R2
  AST_JUMP_ABS: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == 3'd1) |=> pc_o == $past(abs_tgt_i)); // R3
  AST_CALL_ABS_PC: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == 3'd3) |=> pc_o == $past(abs_tgt_i)); // R5
  AST_CALL_SP: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == 3'd3 || ctl_i == 3'd4) |=> sp_o == $past(sp_o) - SP_W'(2)); // R6
  AST_WR_ADDR: assert property (@(posedge clk) disable iff (rst)
    st_we_o |-> st_wr_addr_o == sp_o - SP_W'(1)); // R7
  AST_RET_SP: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == 3'd5) |=> sp_o == $past(sp_o) + SP_W'(2)); // R8
  AST_RD_ADDR: assert property (@(posedge clk) disable iff (rst)
    st_rd_addr_o == sp_o + SP_W'(1)); // R8
  AST_SKIP_LONG: assert property (@(posedge clk) disable iff (rst)
    (ctl_i == 3'd6 && two_word_i) |=> pc_o == $past(pc_o) + PC_W'(3)); // R9
  AST_SP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ctl_i != 3'd3 && ctl_i != 3'd4 && ctl_i != 3'd5) |=> sp_o == $past(sp_o)); // R10
endmodule

bind prog_seq prog_seq_chk #(
  .PC_W  (PC_W),
  .SP_W  (SP_W),
  .SP_TOP(SP_TOP)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctl_i       (ctl_i),
  .two_word_i  (two_word_i),
  .abs_tgt_i   (abs_tgt_i),
  .pc_o        (pc_o),
  .sp_o        (sp_o),
  .st_we_o     (st_we_o),
  .st_wr_addr_o(st_wr_addr_o),
  .st_rd_addr_o(st_rd_addr_o)
);

// File: tb/sim_prog_seq.sv
module sim_prog_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] TOP = 16'h00FE;

  typedef struct packed {
    logic [2:0]  ctl;
    logic        two;
    logic [11:0] k;
    logic [15:0] tgt;
    logic [15:0] pc;
    logic [15:0] sp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [0:NV-1] = '{
    '{3'd0, 1'b0, 12'h000, 16'h0000, 16'h0001, 16'h00FE},
    '{3'd0, 1'b1, 12'h000, 16'h0000, 16'h0003, 16'h00FE},
    '{3'd2, 1'b0, 12'h005, 16'h0000, 16'h0009, 16'h00FE},
    '{3'd2, 1'b0, 12'hFFC, 16'h0000, 16'h0006, 16'h00FE},
    '{3'd3, 1'b0, 12'h000, 16'h1234, 16'h1234, 16'h00FC},
    '{3'd4, 1'b0, 12'h010, 16'h0000, 16'h1245, 16'h00FA},
    '{3'd6, 1'b0, 12'h000, 16'h0000, 16'h1247, 16'h00FA},
    '{3'd6, 1'b1, 12'h000, 16'h0000, 16'h124A, 16'h00FA},
    '{3'd5, 1'b0, 12'h000, 16'h0000, 16'h1235, 16'h00FC},
    '{3'd5, 1'b0, 12'h000, 16'h0000, 16'h0008, 16'h00FE},
    '{3'd1, 1'b0, 12'h000, 16'hFFFF, 16'hFFFF, 16'h00FE},
    '{3'd0, 1'b0, 12'h000, 16'h0000, 16'h0000, 16'h00FE},
    '{3'd2, 1'b0, 12'h800, 16'h0000, 16'hF801, 16'h00FE},
    '{3'd2, 1'b0, 12'h7FF, 16'h0000, 16'h0001, 16'h00FE},
    '{3'd7, 1'b0, 12'h000, 16'h0000, 16'h0002, 16'h00FE},
    '{3'd4, 1'b0, 12'h7FF, 16'h0000, 16'h0802, 16'h00FC},
    '{3'd5, 1'b0, 12'h000, 16'h0000, 16'h0003, 16'h00FE}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  ctl = 3'd0;
  logic        two = 1'b0;
  logic [11:0] k = '0;
  logic [15:0] tgt = '0;
  logic [15:0] rd_data;
  logic [15:0] pc, sp, wr_addr, wr_data, rd_addr;
  logic        we;
  logic [7:0]  smem [0:255];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prog_seq #(.SP_TOP(TOP)) u0 (
    .clk(clk), .rst(rst), .ctl_i(ctl), .two_word_i(two), .rel_off_i(k),
    .abs_tgt_i(tgt), .st_rd_data_i(rd_data), .pc_o(pc), .sp_o(sp),
    .st_we_o(we), .st_wr_addr_o(wr_addr), .st_wr_data_o(wr_data),
    .st_rd_addr_o(rd_addr)
  );

  // byte-addressed stack model: write on the edge, read combinationally
  always @(posedge clk) begin
    if (we) begin
      smem[wr_addr[7:0]]          <= wr_data[7:0];
      smem[8'(wr_addr[7:0] + 1)]  <= wr_data[15:8];
    end
  end
  assign rd_data = {smem[8'(rd_addr[7:0] + 1)], smem[rd_addr[7:0]]};

  function automatic string tag_of(logic [2:0] c);
    case (c)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) smem[i] = 8'h00;
    rst = 1'b1;
    step();
    check("R1 pc", pc, 16'h0000);
    check("R1 sp", sp, TOP);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      ctl = VECS[i].ctl; two = VECS[i].two; k = VECS[i].k; tgt = VECS[i].tgt;
      step();
      check({tag_of(VECS[i].ctl), " pc"}, pc, VECS[i].pc);
      check({"R10 sp ", tag_of(VECS[i].ctl)}, sp, VECS[i].sp);
    end

    // R7: write port during an absolute call from pc=3, sp=FE (return 5)
    ctl = 3'd3; two = 1'b0; tgt = 16'h4000;
    #1;
    check("R7 we", 16'(we), 16'h0001);
    check("R7 wr_addr", wr_addr, 16'h00FD);
    check("R7 wr_data", wr_data, 16'h0500);
    step();
    check("R5 pc", pc, 16'h4000);
    check("R5 sp", sp, 16'h00FC);

    // R8: read address tracks SP+1, return pops 5
    ctl = 3'd5;
    #1;
    check("R8 rd_addr", rd_addr, 16'h00FD);
    check("R7 we low on return", 16'(we), 16'h0000);
    step();
    check("R8 pc", pc, 16'h0005);
    check("R8 sp", sp, 16'h00FE);

    // R1: reset in the middle of a run
    ctl = 3'd1; tgt = 16'hABCD;
    step();
    rst = 1'b1; ctl = 3'd3;
    step();
    check("R1 mid pc", pc, 16'h0000);
    check("R1 mid sp", sp, TOP);
    rst = 1'b0;

    // R9: short skip from 0; R2: two-word step
    ctl = 3'd6; two = 1'b0;
    step();
    check("R9 short skip", pc, 16'h0002);
    ctl = 3'd0; two = 1'b1;
    step();
    check("R2 long step", pc, 16'h0004);
    ctl = 3'd0; two = 1'b0;
    #1;
    check("R7 we low on step", 16'(we), 16'h0000);

    done = 1'b1;
    finish_run();
  end
endmodule